// File: doc/BRIEF.md
# Global Timer with Compare Channel

This block is a memory-mapped timer. It has one 64-bit up-counter that runs freely and one 64-bit compare channel that raises a level interrupt. Software uses a plain 32-bit read/write register bus.

Software starts and stops the counter with a control bit. It can load either 32-bit half of the counter. It loads the compare value as two halves. It can choose a periodic mode, in which the compare value adds a programmed 32-bit step to itself after every match. That mode gives a steady tick without reloads.

Every write to a timing register is acknowledged a fixed number of cycles later by a sticky write-status flag. Software waits for that flag and then clears it by writing a one to it.

Top module: `cmp_timer`

## Requirements
- R1: After reset all registers read zero, `irq_o` is low and the counter does not advance.
- R2: While control bit 8 is set, the counter increases by exactly one on each clock edge. While it is clear, the counter holds its value.
- R3: A write to the counter low half (0x100) or high half (0x104) replaces only that half. Reads of both halves return the live value, so a carry out of the low half shows up in the high half on the same edge.
- R4: With control bit 0 set, a cycle in which the compare value equals the full 64-bit counter sets interrupt-status bit 0 (0x244) on the next edge. The bit stays set until a write to 0x244 with data bit 0 set. With control bit 0 clear, no match is taken.
- R5: `irq_o` is high exactly when interrupt-status bit 0 and interrupt-enable bit 0 (0x248) are both set.
- R6: With control bits 0 and 1 set, every match adds the increment register (0x208) to the compare value (0x200 low half, 0x204 high half). With bit 1 clear, the compare value is left unchanged.
- R7: Each tracked write sets its write-status flag exactly WS_LAT (default 2) clock edges after the edge that accepts it, and the flag reads zero before that. Counter status at 0x110 uses bit 0 for counter low and bit 1 for counter high. Global status at 0x24C uses bit 0 for compare low, bit 1 for compare high, bit 2 for increment and bit 16 for control.
- R8: A write-status flag clears only when a one is written to its own bit position in its status register. Zero bits in the write data leave flags unchanged.
- R9: Reads of unmapped offsets (for example 0x300) return zero. A read never changes any state, including interrupt status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as a read |
| irq_o | output | 1 | Compare interrupt, level high |

## Verification
The bench targets the carry from the low to the high counter half. A design that updates the halves apart from each other would show a stale high half for one cycle.

It measures the exact edge on which the interrupt appears after a match. It also measures the exact edge on which a write-status flag appears, so an off-by-one pipeline is caught.

Periodic mode is run through three matches and the compare value is checked afterwards. Skipping the add, or adding on a disabled channel, gives the wrong value. Partial clears of the status registers and disabling the interrupt enable expose a design that clears whole registers or leaves the output ungated.

// File: rtl/cmp_timer_pkg.sv
// Package: shared register offsets and bit positions for the compare timer.
// Assumes byte offsets fit in 12 bits and the data width is at least 17 bits.
package cmp_timer_pkg;
    localparam int OFF_W = 12;

    localparam logic [OFF_W-1:0] OFF_CNT_LO  = 12'h100;
    localparam logic [OFF_W-1:0] OFF_CNT_HI  = 12'h104;
    localparam logic [OFF_W-1:0] OFF_CNT_WS  = 12'h110;
    localparam logic [OFF_W-1:0] OFF_CMP_LO  = 12'h200;
    localparam logic [OFF_W-1:0] OFF_CMP_HI  = 12'h204;
    localparam logic [OFF_W-1:0] OFF_CMP_INC = 12'h208;
    localparam logic [OFF_W-1:0] OFF_CTRL    = 12'h240;
    localparam logic [OFF_W-1:0] OFF_IST     = 12'h244;
    localparam logic [OFF_W-1:0] OFF_IEN     = 12'h248;
    localparam logic [OFF_W-1:0] OFF_GWS     = 12'h24C;

    // control register fields
    localparam int CTRL_RUN  = 8;
    localparam int CTRL_AINC = 1;
    localparam int CTRL_CEN  = 0;

    // global write-status fields
    localparam int GWS_CTRL = 16;
    localparam int GWS_CLO  = 0;
    localparam int GWS_CHI  = 1;
    localparam int GWS_INC  = 2;

    // counter write-status fields
    localparam int CWS_LO = 0;
    localparam int CWS_HI = 1;

    // index of each tracked write inside the flag vector
    typedef enum int {
        TRK_CNT_LO  = 0,
        TRK_CNT_HI  = 1,
        TRK_CMP_LO  = 2,
        TRK_CMP_HI  = 3,
        TRK_CMP_INC = 4,
        TRK_CTRL    = 5
    } trk_idx_e;
    localparam int TRK_NUM = 6;

    // control register contents
    typedef struct packed {
        logic run;
        logic ainc;
        logic cen;
    } ctrl_t;
endpackage

// File: rtl/cmp_timer_counter.sv
// Module: 64-bit free-running counter built from two loadable halves.
// Assumes at most one half is written per cycle by the bus. A write has
// priority over counting in that cycle.
module cmp_timer_counter #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic [HALF_W-1:0]   wdata_i,
    output logic [2*HALF_W-1:0] cnt_o
);
    localparam int FULL_W = 2 * HALF_W;

    logic [FULL_W-1:0] cnt_q;

    // Purpose: load a half on a write, otherwise count while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_lo_i || wr_hi_i) begin
            cnt_q <= {wr_hi_i ? wdata_i : cnt_q[FULL_W-1:HALF_W],
                      wr_lo_i ? wdata_i : cnt_q[HALF_W-1:0]};
        end else if (run_i) begin
            cnt_q <= cnt_q + FULL_W'(1);
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/cmp_timer_compare.sv
// Module: 64-bit compare channel with an optional self-advancing target.
// Assumes the counter is presented in full width each cycle. A bus write to
// either compare half wins over the automatic advance in the same cycle.
module cmp_timer_compare #(
    parameter int HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                ainc_i,
    input  logic [2*HALF_W-1:0] cnt_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic                wr_inc_i,
    input  logic [HALF_W-1:0]   wdata_i,
    output logic [2*HALF_W-1:0] cmp_o,
    output logic [HALF_W-1:0]   inc_o,
    output logic                match_o
);
    localparam int FULL_W = 2 * HALF_W;

    logic [FULL_W-1:0] cmp_q;
    logic [HALF_W-1:0] inc_q;
    logic              match;

    // Purpose: equality against the live counter, taken only when enabled.
    always_comb begin
        match = en_i && (cnt_i == cmp_q);
    end

    // Purpose: hold the compare target; advance it by the step in periodic mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_lo_i || wr_hi_i) begin
            cmp_q <= {wr_hi_i ? wdata_i : cmp_q[FULL_W-1:HALF_W],
                      wr_lo_i ? wdata_i : cmp_q[HALF_W-1:0]};
        end else if (match && ainc_i) begin
            cmp_q <= cmp_q + {{HALF_W{1'b0}}, inc_q};
        end
    end

    // Purpose: hold the periodic step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_q <= '0;
        end else if (wr_inc_i) begin
            inc_q <= wdata_i;
        end
    end

    assign cmp_o   = cmp_q;
    assign inc_o   = inc_q;
    assign match_o = match;
endmodule

// File: rtl/cmp_timer_wstat.sv
// Module: sticky write-acknowledge flags, one per tracked register.
// Each flag is set LAT edges after its write is accepted and cleared by a
// write-one request. A set that arrives wins over a clear in the same cycle.
// Assumes LAT >= 1.
module cmp_timer_wstat #(
    parameter int NUM = 6,
    parameter int LAT = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] hit_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] flag_o
);
    for (genvar i = 0; i < NUM; i++) begin : g_bit
        logic [LAT-1:0] pipe_q;
        logic           flag_q;

        if (LAT == 1) begin : g_short
            // Purpose: single-stage delay of the write strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= hit_i[i];
            end
        end else begin : g_long
            // Purpose: multi-stage delay of the write strobe.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[LAT-2:0], hit_i[i]};
            end
        end

        // Purpose: sticky flag, set by the delayed strobe and cleared on request.
        always_ff @(posedge clk) begin
            if (!rst_n)               flag_q <= 1'b0;
            else if (pipe_q[LAT-1])   flag_q <= 1'b1;
            else if (clr_i[i])        flag_q <= 1'b0;
        end

        assign flag_o[i] = flag_q;
    end
endmodule

// File: rtl/cmp_timer.sv
// Module: top of the compare timer. It decodes the register bus, holds the
// control, interrupt status and enable bits, and drives the read mux.
// Assumes a single-cycle bus: a write takes effect on the edge where bus_en
// and bus_we are high. Read data is combinational from the address.
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int WS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int FULL_W = 2 * DATA_W;

    // decoded write strobes
    logic wr_cnt_lo, wr_cnt_hi, wr_cws, wr_cmp_lo, wr_cmp_hi, wr_cmp_inc;
    logic wr_ctrl, wr_ist, wr_ien, wr_gws;
    logic wr_en;

    ctrl_t             ctrl_q;
    logic              ist_q;
    logic              ien_q;
    logic [FULL_W-1:0] cnt;
    logic [FULL_W-1:0] cmp;
    logic [DATA_W-1:0] inc;
    logic              match;
    logic [TRK_NUM-1:0] trk_hit;
    logic [TRK_NUM-1:0] trk_clr;
    logic [TRK_NUM-1:0] trk_flag;
    logic              clr_ist;

    // Purpose: turn a bus write into one strobe per register.
    always_comb begin
        wr_en      = bus_en && bus_we;
        wr_cnt_lo  = wr_en && (bus_addr == ADDR_W'(OFF_CNT_LO));
        wr_cnt_hi  = wr_en && (bus_addr == ADDR_W'(OFF_CNT_HI));
        wr_cws     = wr_en && (bus_addr == ADDR_W'(OFF_CNT_WS));
        wr_cmp_lo  = wr_en && (bus_addr == ADDR_W'(OFF_CMP_LO));
        wr_cmp_hi  = wr_en && (bus_addr == ADDR_W'(OFF_CMP_HI));
        wr_cmp_inc = wr_en && (bus_addr == ADDR_W'(OFF_CMP_INC));
        wr_ctrl    = wr_en && (bus_addr == ADDR_W'(OFF_CTRL));
        wr_ist     = wr_en && (bus_addr == ADDR_W'(OFF_IST));
        wr_ien     = wr_en && (bus_addr == ADDR_W'(OFF_IEN));
        wr_gws     = wr_en && (bus_addr == ADDR_W'(OFF_GWS));
        clr_ist    = wr_ist && bus_wdata[0];
    end

    // Purpose: control register with run, auto-increment and compare enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.run  <= bus_wdata[CTRL_RUN];
            ctrl_q.ainc <= bus_wdata[CTRL_AINC];
            ctrl_q.cen  <= bus_wdata[CTRL_CEN];
        end
    end

    // Purpose: pending interrupt, set by a match and cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)       ist_q <= 1'b0;
        else if (match)   ist_q <= 1'b1;
        else if (clr_ist) ist_q <= 1'b0;
    end

    // Purpose: interrupt output enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= 1'b0;
        else if (wr_ien) ien_q <= bus_wdata[0];
    end

    cmp_timer_counter #(.HALF_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (ctrl_q.run),
        .wr_lo_i (wr_cnt_lo),
        .wr_hi_i (wr_cnt_hi),
        .wdata_i (bus_wdata),
        .cnt_o   (cnt)
    );

    cmp_timer_compare #(.HALF_W(DATA_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (ctrl_q.cen),
        .ainc_i   (ctrl_q.ainc),
        .cnt_i    (cnt),
        .wr_lo_i  (wr_cmp_lo),
        .wr_hi_i  (wr_cmp_hi),
        .wr_inc_i (wr_cmp_inc),
        .wdata_i  (bus_wdata),
        .cmp_o    (cmp),
        .inc_o    (inc),
        .match_o  (match)
    );

    // Purpose: collect tracked write strobes and their write-one clear bits.
    always_comb begin
        trk_hit              = '0;
        trk_hit[TRK_CNT_LO]  = wr_cnt_lo;
        trk_hit[TRK_CNT_HI]  = wr_cnt_hi;
        trk_hit[TRK_CMP_LO]  = wr_cmp_lo;
        trk_hit[TRK_CMP_HI]  = wr_cmp_hi;
        trk_hit[TRK_CMP_INC] = wr_cmp_inc;
        trk_hit[TRK_CTRL]    = wr_ctrl;
        trk_clr              = '0;
        trk_clr[TRK_CNT_LO]  = wr_cws && bus_wdata[CWS_LO];
        trk_clr[TRK_CNT_HI]  = wr_cws && bus_wdata[CWS_HI];
        trk_clr[TRK_CMP_LO]  = wr_gws && bus_wdata[GWS_CLO];
        trk_clr[TRK_CMP_HI]  = wr_gws && bus_wdata[GWS_CHI];
        trk_clr[TRK_CMP_INC] = wr_gws && bus_wdata[GWS_INC];
        trk_clr[TRK_CTRL]    = wr_gws && bus_wdata[GWS_CTRL];
    end

    cmp_timer_wstat #(.NUM(TRK_NUM), .LAT(WS_LAT)) u_ws (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (trk_hit),
        .clr_i  (trk_clr),
        .flag_o (trk_flag)
    );

    // Purpose: read mux; unmapped offsets and non-read cycles return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            if (bus_addr == ADDR_W'(OFF_CNT_LO)) begin
                bus_rdata = cnt[DATA_W-1:0];
            end else if (bus_addr == ADDR_W'(OFF_CNT_HI)) begin
                bus_rdata = cnt[FULL_W-1:DATA_W];
            end else if (bus_addr == ADDR_W'(OFF_CNT_WS)) begin
                bus_rdata[CWS_LO] = trk_flag[TRK_CNT_LO];
                bus_rdata[CWS_HI] = trk_flag[TRK_CNT_HI];
            end else if (bus_addr == ADDR_W'(OFF_CMP_LO)) begin
                bus_rdata = cmp[DATA_W-1:0];
            end else if (bus_addr == ADDR_W'(OFF_CMP_HI)) begin
                bus_rdata = cmp[FULL_W-1:DATA_W];
            end else if (bus_addr == ADDR_W'(OFF_CMP_INC)) begin
                bus_rdata = inc;
            end else if (bus_addr == ADDR_W'(OFF_CTRL)) begin
                bus_rdata[CTRL_RUN]  = ctrl_q.run;
                bus_rdata[CTRL_AINC] = ctrl_q.ainc;
                bus_rdata[CTRL_CEN]  = ctrl_q.cen;
            end else if (bus_addr == ADDR_W'(OFF_IST)) begin
                bus_rdata[0] = ist_q;
            end else if (bus_addr == ADDR_W'(OFF_IEN)) begin
                bus_rdata[0] = ien_q;
            end else if (bus_addr == ADDR_W'(OFF_GWS)) begin
                bus_rdata[GWS_CLO]  = trk_flag[TRK_CMP_LO];
                bus_rdata[GWS_CHI]  = trk_flag[TRK_CMP_HI];
                bus_rdata[GWS_INC]  = trk_flag[TRK_CMP_INC];
                bus_rdata[GWS_CTRL] = trk_flag[TRK_CTRL];
            end
        end
    end

    assign irq_o = ist_q && ien_q;
endmodule

// File: rtl/cmp_timer_checker.sv
// Module: property checker for the compare timer, bound to the top.
// Assumes it sees the counter, the compare target and the write strobes of
// the top. It drives nothing.
module cmp_timer_checker #(
    parameter int HALF_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run,
    input logic                ainc,
    input logic                wr_cnt_any,
    input logic                wr_cmp_any,
    input logic [2*HALF_W-1:0] cnt,
    input logic [2*HALF_W-1:0] cmp,
    input logic [HALF_W-1:0]   inc,
    input logic                match,
    input logic                ist,
    input logic                clr_ist
);
    localparam int FULL_W = 2 * HALF_W;

    // R2: a running counter with no load steps by one
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run && !wr_cnt_any |=> cnt == $past(cnt) + FULL_W'(1));

    // R2: a stopped counter with no load holds
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !wr_cnt_any |=> cnt == $past(cnt));

    // R6: a periodic match advances the target by the step
    p_cmp_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        match && ainc && !wr_cmp_any |=>
            cmp == $past(cmp) + {{HALF_W{1'b0}}, $past(inc)});

    // R6: without a periodic match or a write the target is unchanged
    p_cmp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(match && ainc) && !wr_cmp_any |=> cmp == $past(cmp));

    // R4: pending interrupt stays until cleared
    p_ist_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ist && !clr_ist |=> ist);

    // R4: pending interrupt only rises after a match
    p_ist_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ist) |-> $past(match));
endmodule

bind cmp_timer cmp_timer_checker #(.HALF_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl_q.run),
    .ainc       (ctrl_q.ainc),
    .wr_cnt_any (wr_cnt_lo || wr_cnt_hi),
    .wr_cmp_any (wr_cmp_lo || wr_cmp_hi),
    .cnt        (cnt),
    .cmp        (cmp),
    .inc        (inc),
    .match      (match),
    .ist        (ist_q),
    .clr_ist    (clr_ist)
);

// File: tb/cmp_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmp_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write accepted at the next edge; returns at the following falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    // combinational read, no clock edge consumed
    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_en = 1'b0;
        #1;
    endtask

    task automatic clear_ws();
        repeat (4) @(negedge clk);
        wr(12'h24C, 32'h0001_0007);
        wr(12'h110, 32'h3);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h240, v); check("R1 ctrl", v, 0);
        rd(12'h100, v); check("R1 cnt lo", v, 0);
        rd(12'h104, v); check("R1 cnt hi", v, 0);
        rd(12'h24C, v); check("R1 gws", v, 0);
        check("R1 irq", {31'b0, irq_o}, 0);
        repeat (3) @(negedge clk);
        rd(12'h100, v); check("R1 stopped", v, 0);
    endtask

    task automatic t_run();
        logic [31:0] a, b;
        wr(12'h240, 32'h100);
        rd(12'h100, a);
        repeat (7) @(negedge clk);
        rd(12'h100, b); check("R2 step", b - a, 7);
        wr(12'h240, 32'h0);
        rd(12'h100, a);
        repeat (5) @(negedge clk);
        rd(12'h100, b); check("R2 hold", b, a);
    endtask

    task automatic t_carry();
        logic [31:0] v;
        wr(12'h100, 32'hFFFF_FFFE);
        wr(12'h104, 32'h5);
        rd(12'h100, v); check("R3 lo kept", v, 32'hFFFF_FFFE);
        rd(12'h104, v); check("R3 hi", v, 32'h5);
        wr(12'h240, 32'h100);
        rd(12'h100, v); check("R3 before start", v, 32'hFFFF_FFFE);
        @(negedge clk);
        rd(12'h100, v); check("R3 lo ff", v, 32'hFFFF_FFFF);
        rd(12'h104, v); check("R3 hi pre", v, 32'h5);
        @(negedge clk);
        rd(12'h100, v); check("R3 lo wrap", v, 32'h0);
        rd(12'h104, v); check("R3 carry", v, 32'h6);
        wr(12'h240, 32'h0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(12'h100, 0); wr(12'h104, 0);
        wr(12'h200, 32'd20); wr(12'h204, 0);
        wr(12'h244, 1);
        wr(12'h248, 1);
        wr(12'h240, 32'h101);
        repeat (20) @(negedge clk);
        check("R4 irq before match", {31'b0, irq_o}, 0);
        rd(12'h100, v); check("R4 cnt at match", v, 32'd20);
        @(negedge clk);
        check("R4 irq after match", {31'b0, irq_o}, 1);
        rd(12'h244, v); check("R9 read keeps status", v, 1);
        repeat (5) @(negedge clk);
        check("R4 sticky", {31'b0, irq_o}, 1);
        wr(12'h244, 0);
        check("R4 zero write ignored", {31'b0, irq_o}, 1);
        wr(12'h244, 1);
        check("R4 cleared", {31'b0, irq_o}, 0);
        repeat (30) @(negedge clk);
        check("R4 one-shot no repeat", {31'b0, irq_o}, 0);
        rd(12'h200, v); check("R6 no advance", v, 32'd20);
        // R5: gate with enable off
        wr(12'h248, 0);
        wr(12'h100, 32'd10);
        repeat (20) @(negedge clk);
        check("R5 gated low", {31'b0, irq_o}, 0);
        rd(12'h244, v); check("R5 status set", v, 1);
        wr(12'h248, 1);
        check("R5 enabled high", {31'b0, irq_o}, 1);
        wr(12'h244, 1);
        // R4: disabled comparator takes no match
        wr(12'h240, 32'h100);
        wr(12'h100, 32'd10);
        repeat (20) @(negedge clk);
        rd(12'h244, v); check("R4 disabled no match", v, 0);
        wr(12'h240, 32'h0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(12'h100, 0); wr(12'h104, 0);
        wr(12'h200, 32'd5); wr(12'h204, 0);
        wr(12'h208, 32'd10);
        wr(12'h240, 32'h103);
        repeat (30) @(negedge clk);
        rd(12'h200, v); check("R6 advanced thrice", v, 32'd35);
        rd(12'h204, v); check("R6 hi", v, 0);
        rd(12'h244, v); check("R6 status", v, 1);
        wr(12'h240, 32'h0);
        wr(12'h244, 1);
    endtask

    task automatic t_wstat();
        logic [31:0] v;
        clear_ws();
        rd(12'h24C, v); check("R8 cleared gws", v, 0);
        rd(12'h110, v); check("R8 cleared cws", v, 0);
        wr(12'h240, 32'h0);
        rd(12'h24C, v); check("R7 ctrl +0", v, 0);
        @(negedge clk);
        rd(12'h24C, v); check("R7 ctrl +1", v, 0);
        @(negedge clk);
        rd(12'h24C, v); check("R7 ctrl +2", v, 32'h0001_0000);
        wr(12'h24C, 32'h0000_0007);
        rd(12'h24C, v); check("R8 other bits no clear", v, 32'h0001_0000);
        wr(12'h24C, 32'h0001_0000);
        rd(12'h24C, v); check("R8 w1c", v, 0);
        wr(12'h200, 32'd99); wr(12'h204, 0); wr(12'h208, 32'd1);
        repeat (3) @(negedge clk);
        rd(12'h24C, v); check("R7 compare bits", v, 32'h7);
        wr(12'h24C, 32'h2);
        rd(12'h24C, v); check("R8 partial clear", v, 32'h5);
        wr(12'h100, 0); wr(12'h104, 0);
        repeat (3) @(negedge clk);
        rd(12'h110, v); check("R7 counter bits", v, 32'h3);
        wr(12'h110, 32'h1);
        rd(12'h110, v); check("R8 cws partial", v, 32'h2);
        rd(12'h300, v); check("R9 unmapped", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run();
        t_carry();
        t_oneshot();
        t_periodic();
        t_wstat();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule